// File: doc/BRIEF.md
# Asymmetric On/Off Delay Confirmer

This block confirms a single-bit level before passing it on, but only in one direction. In on-delay mode a high input has to be seen on a run of consecutive clock edges before the output goes high, while a low input drives the output low at the next edge. In off-delay mode the roles swap: a low input has to persist before the output drops, and a high input passes at the next edge. An input that returns to its earlier level before the run completes leaves the output untouched, so short pulses of the delayed polarity are filtered out.

The delay is a parameter in clock cycles. A second parameter gives the level the input is assumed to have had before reset; the output register takes that value in reset. When the first sampled input equals this assumed level and is of the delayed polarity, it is confirmed at once and does not wait for the count. The mode pin is taken only while no confirmation run is pending, so a change of mode in the middle of a run cannot cut it short or restart it. Reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `asym_delay_confirm`

## Requirements
- R1: On-delay mode (mode_i = 0): after the input rises, dout_o goes high on the DELAY-th consecutive rising clock edge at which din_i is sampled high, and stays low on the edges before it.
- R2: On-delay mode: once dout_o is high it stays high for as long as din_i stays high.
- R3: On-delay mode: din_i sampled low makes dout_o low at that same clock edge, with no count.
- R4: Off-delay mode (mode_i = 1): after the input falls, dout_o goes low on the DELAY-th consecutive rising edge at which din_i is sampled low, and stays high on the edges before it.
- R5: Off-delay mode: once dout_o is low it stays low for as long as din_i stays low.
- R6: Off-delay mode: din_i sampled high makes dout_o high at that same clock edge, with no count.
- R7: A run of the delayed polarity that ends before it reaches DELAY edges leaves dout_o unchanged, and the next run counts from zero again.
- R8: While rst_n is low, dout_o equals INIT_PREV without waiting for a clock edge; after rst_n rises, the first two clock edges keep that value and the third edge is the first that samples din_i.
- R9: If the first sampled din_i equals INIT_PREV and that level is the delayed polarity of the current mode, dout_o keeps it with no delay; if INIT_PREV is the other level, the full DELAY count applies.
- R10: mode_i is sampled on every edge during reset and, after reset, only on an edge where no run is pending and din_i equals dout_o; a change while a run is pending takes effect after the run, and the run finishes under the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Reset, active low, asserts asynchronously, released through a synchronizer |
| mode_i | input | 1 | 0 = delay rising edges (on-delay), 1 = delay falling edges (off-delay) |
| din_i | input | 1 | Level to be confirmed |
| dout_o | output | 1 | Confirmed level, registered |

## Verification
The bench builds two copies with DELAY = 5 that differ only in INIT_PREV, one with 1 and one with 0, and drives them with the same stimulus. Because of this, every reset scenario covers both branches of the initial-condition rule at the same time: the copy whose assumed level matches the first sample confirms it at once, and the other needs the full five-edge count. A delay of five leaves room for runs of four edges, which must be suppressed, for a run broken after three edges and then restarted, and for a mode change that arrives two edges into a pending run.

// File: rtl/conf_pkg.sv
package conf_pkg;

  typedef enum logic {
    MODE_ON_DELAY  = 1'b0,
    MODE_OFF_DELAY = 1'b1
  } dly_mode_e;

  // Level that reaches the output without a confirmation count.
  function automatic logic pass_level(dly_mode_e m);
    return (m == MODE_OFF_DELAY);
  endfunction

endpackage

// File: rtl/confirm_rst_sync.sv
module confirm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/confirm_timer.sv
module confirm_timer #(
  parameter int unsigned DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o,
  output logic busy_o
);

  localparam int unsigned CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i && at_last;
  assign busy_o   = (cnt_q != '0);

  // Advance while a run is in progress; fall back to zero otherwise.
  always_comb begin
    cnt_en = run_i || busy_o;
    if (run_i && !at_last) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1

  AST_RUN_BROKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/confirm_mode.sv
module confirm_mode
  import conf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_i,
  input  logic      mode_i,
  output dly_mode_e mode_o
);

  dly_mode_e mode_q;
  dly_mode_e mode_d;
  logic      mode_en;

  // During reset the pin is followed on every edge so the first
  // functional edge already sees the intended mode.
  always_comb begin
    mode_en = !rst_n || ld_i;
    mode_d  = dly_mode_e'(mode_i);
  end

  always_ff @(posedge clk) begin
    if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/asym_delay_confirm.sv
module asym_delay_confirm
  import conf_pkg::*;
#(
  parameter int unsigned DELAY     = 8,
  parameter logic        INIT_PREV = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic din_i,
  output logic dout_o
);

  logic      rst_core_n;
  dly_mode_e mode_q;
  logic      fast_lvl;
  logic      slow_lvl;
  logic      run;
  logic      expire;
  logic      busy;
  logic      mode_ld;
  logic      q_q;
  logic      q_d;
  logic      q_en;

  confirm_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  confirm_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ld_i   (mode_ld),
    .mode_i (mode_i),
    .mode_o (mode_q)
  );

  confirm_timer #(
    .DELAY (DELAY)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run_i    (run),
    .expire_o (expire),
    .busy_o   (busy)
  );

  assign fast_lvl = pass_level(mode_q);
  assign slow_lvl = !fast_lvl;

  // A run lasts while the output still shows the pass level and the
  // input shows the level that needs confirmation.
  assign run     = (q_q == fast_lvl) && (din_i == slow_lvl);
  assign mode_ld = !busy && (din_i == q_q);

  always_comb begin
    q_en = (din_i == fast_lvl) || expire;
    if (din_i == fast_lvl) begin
      q_d = fast_lvl;
    end else begin
      q_d = slow_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      q_q <= INIT_PREV;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign dout_o = q_q;

  AST_FAST_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (din_i == fast_lvl) |=> (dout_o == $past(fast_lvl))); // R3, R6

  AST_SLOW_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((dout_o != $past(dout_o)) && (dout_o == $past(slow_lvl))) |-> $past(expire)); // R1, R4

  AST_SLOW_HELD: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((dout_o == slow_lvl) && (din_i == slow_lvl)) |=> (dout_o == $past(dout_o))); // R2, R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |=> (mode_q == $past(mode_q))); // R10

endmodule

// File: tb/sim_asym_delay_confirm.sv
module sim_asym_delay_confirm;

  localparam int unsigned DLY = 5;

  logic clk;
  logic rst_n;
  logic mode;
  logic din;
  logic dout0;
  logic dout1;

  int n_chk;
  int n_err;
  bit done;

  asym_delay_confirm #(.DELAY(DLY), .INIT_PREV(1'b1)) u0 (
    .clk (clk), .rst_n (rst_n), .mode_i (mode), .din_i (din), .dout_o (dout0)
  );

  asym_delay_confirm #(.DELAY(DLY), .INIT_PREV(1'b0)) u1 (
    .clk (clk), .rst_n (rst_n), .mode_i (mode), .din_i (din), .dout_o (dout1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    end
  endtask

  task automatic step(input logic d);
    din = d;
    @(negedge clk);
  endtask

  // R8: reset value during reset and through the two release edges.
  task automatic do_reset(input logic m, input logic d);
    rst_n = 1'b0;
    mode  = m;
    din   = d;
    repeat (3) @(negedge clk);
    chk("R8", "u0 in reset", dout0, 1'b1);
    chk("R8", "u1 in reset", dout1, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "u0 after release", dout0, 1'b1);
    chk("R8", "u1 after release", dout1, 1'b0);
  endtask

  task automatic t_init_on();
    do_reset(1'b0, 1'b1);
    for (int i = 1; i <= 5; i++) begin
      step(1'b1);
      chk("R9", "u0 first high kept", dout0, 1'b1);
      chk("R1", "u1 rise count", dout1, logic'(i == 5));
    end
    for (int i = 0; i < 10; i++) begin
      step(1'b1);
      chk("R2", "u0 high held", dout0, 1'b1);
      chk("R2", "u1 high held", dout1, 1'b1);
    end
    step(1'b0);
    chk("R3", "u0 fast fall", dout0, 1'b0);
    chk("R3", "u1 fast fall", dout1, 1'b0);
  endtask

  task automatic t_init_off();
    do_reset(1'b1, 1'b0);
    for (int i = 1; i <= 5; i++) begin
      step(1'b0);
      chk("R9", "u1 first low kept", dout1, 1'b0);
      chk("R4", "u0 fall count", dout0, logic'(i < 5));
    end
    for (int i = 0; i < 10; i++) begin
      step(1'b0);
      chk("R5", "u0 low held", dout0, 1'b0);
      chk("R5", "u1 low held", dout1, 1'b0);
    end
    step(1'b1);
    chk("R6", "u0 fast rise", dout0, 1'b1);
    chk("R6", "u1 fast rise", dout1, 1'b1);
  endtask

  task automatic t_on_pulse();
    do_reset(1'b0, 1'b0);
    step(1'b0);
    chk("R3", "u0 settles low", dout0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(1'b1);
      chk("R7", "short high pulse", dout1, 1'b0);
    end
    step(1'b0);
    chk("R7", "after short pulse", dout1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1);
    step(1'b0);
    chk("R7", "broken run", dout0, 1'b0);
    for (int i = 1; i <= 5; i++) begin
      step(1'b1);
      chk("R7", "restart counts from zero", dout0, logic'(i == 5));
    end
  endtask

  task automatic t_off_pulse();
    do_reset(1'b1, 1'b1);
    step(1'b1);
    chk("R6", "u1 settles high", dout1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0);
      chk("R7", "short low pulse", dout1, 1'b1);
    end
    step(1'b1);
    chk("R7", "after short low pulse", dout0, 1'b1);
    for (int i = 1; i <= 5; i++) begin
      step(1'b0);
      chk("R7", "off restart", dout1, logic'(i < 5));
    end
  endtask

  task automatic t_mode_defer();
    do_reset(1'b0, 1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b1);
    step(1'b1);
    chk("R10", "run pending", dout0, 1'b0);
    mode = 1'b1;
    step(1'b1);
    step(1'b1);
    chk("R10", "old mode still counting", dout0, 1'b0);
    step(1'b1);
    chk("R10", "run completes under old mode", dout0, 1'b1);
    step(1'b1);
    for (int i = 1; i <= 5; i++) begin
      step(1'b0);
      chk("R10", "new mode delays fall", dout0, logic'(i < 5));
    end
    mode = 1'b0;
    step(1'b0);
    for (int i = 1; i <= 5; i++) begin
      step(1'b1);
      chk("R10", "idle switch back delays rise", dout1, logic'(i == 5));
    end
  endtask

  task automatic t_async_reset();
    chk("R8", "u1 high before reset", dout1, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R8", "u1 async to init", dout1, 1'b0);
    chk("R8", "u0 async to init", dout0, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    mode  = 1'b0;
    din   = 1'b0;
    t_init_on();
    t_init_off();
    t_on_pulse();
    t_off_pulse();
    t_mode_defer();
    t_async_reset();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

endmodule